// File: doc/BRIEF.md
# CAN Node Fault Confinement Tracker

This block keeps the error bookkeeping of one CAN node. The protocol engine tells it when an error or a successful exchange has happened and whether the node was transmitting at the time. From that it maintains a transmit error count and a receive error count and places the node in one of three confinement states: error-active, error-passive or bus-off. It also watches the sampled bus bit stream on each bit-sample strobe. Inside the stuffed part of a frame it flags a stuffing violation when recessive bits run too long. While the node is in bus-off it counts runs of recessive bits to decide when the node may rejoin the bus.

The bus level arrives already sampled: `bus_recessive` is 1 when the differential voltage between the lines is zero, and that includes the case where the two lines are shorted together. A shorted bus therefore looks like an endless recessive stream. The block does not lock the node out in that case. Recovery completes after the required number of recessive runs, and any later errors drive the node back into bus-off, so on a faulty bus the node cycles between the two.

States and transitions, encoded on `fc_state`: ERR_ACTIVE (2'b00), ERR_PASSIVE (2'b01), BUS_OFF (2'b10). The named transitions are: GO_PASSIVE (ERR_ACTIVE to ERR_PASSIVE, when either count exceeds 127), GO_ACTIVE (ERR_PASSIVE to ERR_ACTIVE, when both counts are at or below 127), GO_BUSOFF (from ERR_ACTIVE or ERR_PASSIVE to BUS_OFF, when the transmit count exceeds 255; this takes priority over the other two), and REJOIN (BUS_OFF to ERR_ACTIVE, when recovery completes). The state register follows the counters one clock later.

Top module: `can_fault_confine`

## Requirements
- R1: After reset `fc_state` is ERR_ACTIVE (2'b00), `tec` and `rec` are 0, and `stuff_err` and `recovery_done` are 0. `fc_state` never takes the value 2'b11.
- R2: With `node_tx`=1, an `err_pulse` adds 8 to `tec`. An `ok_pulse` subtracts 1, but never takes the count below 0. If both pulses arrive in the same cycle, only the error counts.
- R3: With `node_tx`=0, an `err_pulse` adds 1 to `rec`. An `ok_pulse` subtracts 1, but never takes the count below 0. Both pulses in the same cycle count as an error only, and `rec` saturates at 511 instead of wrapping.
- R4: Outside BUS_OFF, the node takes GO_PASSIVE when `tec` or `rec` exceeds 127, and takes GO_ACTIVE when both are 127 or less.
- R5: GO_BUSOFF is taken when `tec` exceeds 255. While the node is in BUS_OFF, error and success pulses leave both counters unchanged.
- R6: In BUS_OFF, recovery needs 128 completed runs of 11 consecutive recessive bits (`bus_recessive`=1). A dominant bit restarts only the current run and keeps the count of runs already completed. Bus values are taken only on cycles with `bit_strobe`=1.
- R7: On the strobe that completes the 128th run, the REJOIN transition sets `fc_state` to ERR_ACTIVE, clears both counters, and raises `recovery_done` for exactly one cycle.
- R8: Nothing prevents a repeat. After REJOIN, new transmit errors take the node back into BUS_OFF, and another 128 runs bring it out again, as often as this happens.
- R9: While `in_stuff_region`=1, the sixth consecutive strobed recessive bit raises `stuff_err` for one cycle. Further recessive bits in the same run raise nothing more. A dominant bit, or `in_stuff_region` going to 0, restarts the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_strobe | input | 1 | One-cycle pulse when a bus bit has been sampled |
| bus_recessive | input | 1 | Sampled bus level, 1 = recessive (zero differential) |
| node_tx | input | 1 | 1 while the node is the transmitter; routes pulses to the transmit count |
| in_stuff_region | input | 1 | 1 while the bus is inside the stuffed part of a frame |
| err_pulse | input | 1 | One-cycle error event from the protocol engine |
| ok_pulse | input | 1 | One-cycle successful transfer event |
| fc_state | output | 2 | Confinement state: 00 active, 01 passive, 10 bus-off |
| tec | output | 9 | Transmit error count |
| rec | output | 9 | Receive error count |
| stuff_err | output | 1 | One-cycle stuffing violation flag |
| recovery_done | output | 1 | One-cycle flag on completion of bus-off recovery |

## Verification
The bench targets the exact thresholds. It checks the state at counts of 127 and 128, and at a transmit count of 248 against 256. A design that used >= instead of > would change state one error too early. It breaks the 128th run with a dominant bit after ten recessive bits and then holds the bus idle without strobes. A tracker that cleared the completed runs, or that counted unstrobed cycles, would rejoin too early or too late. It keeps the bus recessive after a rejoin to show the bus-off cycle repeats, where a sticky lockout would leave the node stranded. It also exercises the floor at zero, error-over-success priority, saturation of the receive count, and the rule of one `stuff_err` per run.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

    typedef enum logic [1:0] {
        FC_ERR_ACTIVE  = 2'b00,
        FC_ERR_PASSIVE = 2'b01,
        FC_BUS_OFF     = 2'b10
    } fc_state_e;

    // Saturating add of a small step to an unsigned count.
    function automatic logic [8:0] sat_add9(input logic [8:0] val, input logic [8:0] step);
        logic [9:0] wide;
        wide = {1'b0, val} + {1'b0, step};
        return wide[9] ? 9'h1FF : wide[8:0];
    endfunction

endpackage

// File: rtl/fc_err_counters.sv
module fc_err_counters #(
    parameter int CNT_W   = 9,
    parameter int TX_STEP = 8,
    parameter int RX_STEP = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze,
    input  logic             clear,
    input  logic             node_tx,
    input  logic             err_pulse,
    input  logic             ok_pulse,
    output logic [CNT_W-1:0] tec,
    output logic [CNT_W-1:0] rec
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam int               NCH     = 2;

    logic [CNT_W-1:0] cnt_q   [NCH];
    logic [CNT_W-1:0] cnt_nxt [NCH];

    // Channel 0 counts transmit events, channel 1 receive events.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        localparam logic [CNT_W-1:0] STEP = (ch == 0) ? CNT_W'(TX_STEP) : CNT_W'(RX_STEP);
        logic sel;

        assign sel = (ch == 0) ? node_tx : !node_tx;

        always_comb begin
            cnt_nxt[ch] = cnt_q[ch];
            if (sel && err_pulse) begin
                if (cnt_q[ch] > CNT_MAX - STEP)
                    cnt_nxt[ch] = CNT_MAX;
                else
                    cnt_nxt[ch] = cnt_q[ch] + STEP;
            end else if (sel && ok_pulse && cnt_q[ch] != '0) begin
                cnt_nxt[ch] = cnt_q[ch] - 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                cnt_q[ch] <= '0;
            else if (!freeze)
                cnt_q[ch] <= cnt_nxt[ch];
        end
    end

    assign tec = cnt_q[0];
    assign rec = cnt_q[1];

endmodule

// File: rtl/fc_stuff_monitor.sv
module fc_stuff_monitor #(
    parameter int STUFF_LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_strobe,
    input  logic bus_recessive,
    input  logic in_stuff_region,
    output logic stuff_err
);
    localparam int SW = $clog2(STUFF_LEN + 1);
    localparam logic [SW-1:0] LAST = SW'(STUFF_LEN - 1);
    localparam logic [SW-1:0] FULL = SW'(STUFF_LEN);

    logic [SW-1:0] run_q;
    logic          hit;

    assign hit = bit_strobe && in_stuff_region && bus_recessive && (run_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= '0;
            stuff_err <= 1'b0;
        end else begin
            stuff_err <= hit;
            if (!in_stuff_region)
                run_q <= '0;
            else if (bit_strobe) begin
                if (!bus_recessive)
                    run_q <= '0;
                else if (run_q != FULL)
                    run_q <= run_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fc_recovery_counter.sv
module fc_recovery_counter #(
    parameter int RUN_LEN   = 11,
    parameter int RUN_TOTAL = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic bit_strobe,
    input  logic bus_recessive,
    output logic recov_hit
);
    localparam int BW = $clog2(RUN_LEN);
    localparam int RW = $clog2(RUN_TOTAL);
    localparam logic [BW-1:0] BIT_LAST = BW'(RUN_LEN - 1);
    localparam logic [RW-1:0] RUN_LAST = RW'(RUN_TOTAL - 1);

    logic [BW-1:0] bit_q;
    logic [RW-1:0] run_q;
    logic          run_end;

    assign run_end   = armed && bit_strobe && bus_recessive && (bit_q == BIT_LAST);
    assign recov_hit = run_end && (run_q == RUN_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !armed) begin
            bit_q <= '0;
            run_q <= '0;
        end else if (bit_strobe) begin
            if (!bus_recessive) begin
                bit_q <= '0;
            end else if (run_end) begin
                bit_q <= '0;
                run_q <= (run_q == RUN_LAST) ? '0 : run_q + 1'b1;
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fc_state_fsm.sv
module fc_state_fsm
    import can_fc_pkg::*;
#(
    parameter int CNT_W       = 9,
    parameter int PASSIVE_LIM = 127,
    parameter int BUSOFF_LIM  = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tec,
    input  logic [CNT_W-1:0] rec,
    input  logic             recov_hit,
    output logic [1:0]       state_code,
    output logic             in_bus_off
);
    localparam logic [CNT_W-1:0] P_LIM = CNT_W'(PASSIVE_LIM);
    localparam logic [CNT_W-1:0] B_LIM = CNT_W'(BUSOFF_LIM);

    fc_state_e state_q, state_d;
    logic      over_busoff, over_passive;

    assign over_busoff  = tec > B_LIM;
    assign over_passive = (tec > P_LIM) || (rec > P_LIM);

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= FC_ERR_ACTIVE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FC_ERR_ACTIVE: begin
                if (over_busoff)       state_d = FC_BUS_OFF;      // GO_BUSOFF
                else if (over_passive) state_d = FC_ERR_PASSIVE;  // GO_PASSIVE
            end
            FC_ERR_PASSIVE: begin
                if (over_busoff)       state_d = FC_BUS_OFF;      // GO_BUSOFF
                else if (!over_passive) state_d = FC_ERR_ACTIVE;  // GO_ACTIVE
            end
            FC_BUS_OFF: begin
                if (recov_hit)         state_d = FC_ERR_ACTIVE;   // REJOIN
            end
            default:                   state_d = FC_ERR_ACTIVE;
        endcase
    end

    always_comb begin
        state_code = state_q;
        in_bus_off = (state_q == FC_BUS_OFF);
    end

endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine #(
    parameter int CNT_W       = 9,
    parameter int TX_STEP     = 8,
    parameter int RX_STEP     = 1,
    parameter int PASSIVE_LIM = 127,
    parameter int BUSOFF_LIM  = 255,
    parameter int RUN_LEN     = 11,
    parameter int RUN_TOTAL   = 128,
    parameter int STUFF_LEN   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_strobe,
    input  logic             bus_recessive,
    input  logic             node_tx,
    input  logic             in_stuff_region,
    input  logic             err_pulse,
    input  logic             ok_pulse,
    output logic [1:0]       fc_state,
    output logic [CNT_W-1:0] tec,
    output logic [CNT_W-1:0] rec,
    output logic             stuff_err,
    output logic             recovery_done
);
    logic in_bus_off;
    logic recov_hit;

    fc_err_counters #(
        .CNT_W   (CNT_W),
        .TX_STEP (TX_STEP),
        .RX_STEP (RX_STEP)
    ) u_counters (
        .clk       (clk),
        .rst_n     (rst_n),
        .freeze    (in_bus_off),
        .clear     (recov_hit),
        .node_tx   (node_tx),
        .err_pulse (err_pulse),
        .ok_pulse  (ok_pulse),
        .tec       (tec),
        .rec       (rec)
    );

    fc_state_fsm #(
        .CNT_W       (CNT_W),
        .PASSIVE_LIM (PASSIVE_LIM),
        .BUSOFF_LIM  (BUSOFF_LIM)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tec        (tec),
        .rec        (rec),
        .recov_hit  (recov_hit),
        .state_code (fc_state),
        .in_bus_off (in_bus_off)
    );

    fc_recovery_counter #(
        .RUN_LEN   (RUN_LEN),
        .RUN_TOTAL (RUN_TOTAL)
    ) u_recovery (
        .clk           (clk),
        .rst_n         (rst_n),
        .armed         (in_bus_off),
        .bit_strobe    (bit_strobe),
        .bus_recessive (bus_recessive),
        .recov_hit     (recov_hit)
    );

    fc_stuff_monitor #(
        .STUFF_LEN (STUFF_LEN)
    ) u_stuff (
        .clk             (clk),
        .rst_n           (rst_n),
        .bit_strobe      (bit_strobe),
        .bus_recessive   (bus_recessive),
        .in_stuff_region (in_stuff_region),
        .stuff_err       (stuff_err)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            recovery_done <= 1'b0;
        else
            recovery_done <= recov_hit;
    end

endmodule

// File: rtl/can_fault_confine_chk.sv
module can_fault_confine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] fc_state,
    input logic [8:0] tec,
    input logic [8:0] rec,
    input logic       stuff_err,
    input logic       recovery_done
);
    assert_legal_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fc_state != 2'b11);

    assert_tec_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (recovery_done || ({1'b0, tec} <= {1'b0, $past(tec)} + 10'd8)));

    assert_rec_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (recovery_done || ({1'b0, rec} <= {1'b0, $past(rec)} + 10'd1)));

    assert_passive_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_state != 2'b10 && tec <= 9'd255 && (tec > 9'd127 || rec > 9'd127))
        |=> fc_state == 2'b01);

    assert_busoff_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_state != 2'b10 && tec > 9'd255) |=> fc_state == 2'b10);

    assert_busoff_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_state == 2'b10) |=> (recovery_done || ($stable(tec) && $stable(rec))));

    assert_rejoin_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        recovery_done |-> (tec == 9'd0 && rec == 9'd0 && fc_state == 2'b00));

    assert_rejoin_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        recovery_done |=> !recovery_done);

    assert_stuff_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_err |=> !stuff_err);

endmodule

bind can_fault_confine can_fault_confine_chk u_fc_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fc_state      (fc_state),
    .tec           (tec),
    .rec           (rec),
    .stuff_err     (stuff_err),
    .recovery_done (recovery_done)
);

// File: tb/test_can_fault_confine.sv
`timescale 1ns/1ps
module test_can_fault_confine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_strobe = 1'b0;
    logic       bus_recessive = 1'b1;
    logic       node_tx = 1'b0;
    logic       in_stuff_region = 1'b0;
    logic       err_pulse = 1'b0;
    logic       ok_pulse = 1'b0;
    logic [1:0] fc_state;
    logic [8:0] tec, rec;
    logic       stuff_err, recovery_done;

    int n_checks = 0;
    int n_fail   = 0;
    int rd_seen  = 0;
    int se_seen  = 0;
    int m_tec = 0, m_rec = 0, m_state = 0;

    always #2 clk = ~clk;   // 250 MHz

    can_fault_confine i_can_fault_confine (
        .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .bus_recessive(bus_recessive),
        .node_tx(node_tx), .in_stuff_region(in_stuff_region), .err_pulse(err_pulse),
        .ok_pulse(ok_pulse), .fc_state(fc_state), .tec(tec), .rec(rec),
        .stuff_err(stuff_err), .recovery_done(recovery_done)
    );

    always @(negedge clk) begin
        if (rst_n && recovery_done) rd_seen++;
        if (rst_n && stuff_err)     se_seen++;
    end

    function automatic int exp_state(input int t, input int r, input int cur);
        if (cur == 2)  return 2;
        if (t > 255)   return 2;
        if (t > 127 || r > 127) return 1;
        return 0;
    endfunction

    function automatic int cnt_after(input int c, input bit e, input bit o, input int step);
        if (e) return (c + step > 511) ? 511 : c + step;
        if (o) return (c > 0) ? c - 1 : 0;
        return c;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check({req, " tec"}, int'(tec), m_tec);
        check({req, " rec"}, int'(rec), m_rec);
        check({req, " state"}, int'(fc_state), m_state);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_tec = 0; m_rec = 0; m_state = 0;
        @(negedge clk);
    endtask

    task automatic op(input bit tx, input bit e, input bit o);
        @(negedge clk);
        node_tx = tx; err_pulse = e; ok_pulse = o;
        @(negedge clk);
        err_pulse = 1'b0; ok_pulse = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (m_state != 2) begin
            if (tx) m_tec = cnt_after(m_tec, e, o, 8);
            else    m_rec = cnt_after(m_rec, e, o, 1);
        end
        m_state = exp_state(m_tec, m_rec, m_state);
    endtask

    task automatic send_bit(input bit lvl);
        @(negedge clk);
        bus_recessive = lvl; bit_strobe = 1'b1;
        @(negedge clk);
        bit_strobe = 1'b0;
    endtask

    task automatic send_runs(input int nruns);
        for (int i = 0; i < nruns * 11; i++) send_bit(1'b1);
    endtask

    // Full recovery on a recessive bus, with checks just before and after.
    task automatic recover_full(input string req);
        int rd0;
        rd0 = rd_seen;
        send_runs(127);
        for (int i = 0; i < 10; i++) send_bit(1'b1);
        @(negedge clk);
        check({req, " still bus-off before last bit"}, int'(fc_state), 2);
        send_bit(1'b1);
        @(negedge clk);
        m_tec = 0; m_rec = 0; m_state = 0;
        check({req, " recovery_done pulses"}, rd_seen - rd0, 1);
        check_all(req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7331));
        do_reset();

        // R1 reset state
        check_all("R1 reset");
        check("R1 stuff_err", int'(stuff_err), 0);
        check("R1 recovery_done", int'(recovery_done), 0);

        // R2 transmit counting, floor, priority
        op(1, 0, 1); check_all("R2 floor at zero");
        op(1, 1, 0); check_all("R2 +8");
        op(1, 0, 1); check_all("R2 -1");
        op(1, 1, 1); check_all("R2 error wins");
        check("R2 value", int'(tec), 15);
        do_reset();

        // R3 / R4 receive counting and passive boundary
        op(0, 0, 1); check_all("R3 floor at zero");
        for (int i = 0; i < 127; i++) op(0, 1, 0);
        check_all("R4 at 127 active");
        check("R4 active at 127", int'(fc_state), 0);
        op(0, 1, 0); check_all("R4 at 128 passive");
        check("R4 passive at 128", int'(fc_state), 1);
        op(0, 0, 1); check_all("R4 back to active");
        op(0, 1, 1); check_all("R3 error wins");
        for (int i = 0; i < 400; i++) op(0, 1, 0);
        check("R3 saturation", int'(rec), 511);
        do_reset();

        // R5 bus-off entry and freeze
        for (int i = 0; i < 31; i++) op(1, 1, 0);
        check_all("R5 at 248");
        check("R5 passive at 248", int'(fc_state), 1);
        op(1, 1, 0); check_all("R5 at 256");
        check("R5 bus-off", int'(fc_state), 2);
        op(1, 0, 1); check_all("R5 ok ignored");
        op(0, 1, 0); check_all("R5 rx error ignored");
        op(1, 1, 0); check_all("R5 tx error ignored");

        // R6 dominant break keeps completed runs; only strobes count
        send_runs(127);
        for (int i = 0; i < 10; i++) send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 0; i < 10; i++) send_bit(1'b1);
        @(negedge clk);
        bus_recessive = 1'b1; repeat (30) @(negedge clk);
        bus_recessive = 1'b0; repeat (5) @(negedge clk);
        bus_recessive = 1'b1; repeat (30) @(negedge clk);
        check("R6 no rejoin without strobes", int'(fc_state), 2);
        check("R6 no early recovery_done", rd_seen, 0);
        send_bit(1'b1);
        @(negedge clk);
        m_tec = 0; m_rec = 0; m_state = 0;
        check("R7 recovery_done pulse", rd_seen, 1);
        check_all("R7 rejoin clears");

        // R8 shorted bus: re-enter bus-off and recover again, twice
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 32; i++) op(1, 1, 0);
            check("R8 re-entered bus-off", int'(fc_state), 2);
            recover_full("R8 repeat recovery");
        end
        check("R8 total recoveries", rd_seen, 3);

        // R9 stuffing violation
        in_stuff_region = 1'b1;
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        @(negedge clk);
        check("R9 no flag after five", se_seen, 0);
        send_bit(1'b1);
        @(negedge clk);
        check("R9 flag on sixth", se_seen, 1);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        @(negedge clk);
        check("R9 one flag per run", se_seen, 1);
        send_bit(1'b0);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        @(negedge clk); in_stuff_region = 1'b0; @(negedge clk); in_stuff_region = 1'b1;
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        @(negedge clk);
        check("R9 region exit restarts", se_seen, 1);
        in_stuff_region = 1'b0;
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        @(negedge clk);
        check("R9 ignored outside region", se_seen, 1);

        // Random traffic (R2 R3 R4 R5)
        do_reset();
        for (int i = 0; i < 300; i++) begin
            int r;
            bit tx, e, o;
            r  = int'($urandom % 100);
            tx = (r < 45);
            e  = tx ? (r < 12) : (r < 80);
            o  = (($urandom % 3) != 0);
            op(tx, e, o);
            check_all("R2 R3 R4 R5 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule